// File: doc/BRIEF.md
# Direct Page Address Formation Unit

This block keeps two small registers on a byte-wide register bus: an 8-bit page index for direct addressing and a 7-bit global page. For every direct-mode access it builds the memory address from these registers and the 8-bit operand offset of the instruction. A local access yields a 16-bit address, with the page index as the high byte and the offset as the low byte. A global access also places the global page in bits 22 to 16, which gives a 23-bit address.

The page index register is protected by an operating-mode rule. While the `special_mode` input is high it can be rewritten freely. Outside special mode only the first write after reset is accepted. That write sets a sticky lock, and only reset clears the lock. The global page register has no such restriction.

Address formation is purely combinational from the current register contents. An access that falls in the same cycle as a register write therefore still sees the old value, and the new value applies from the next cycle on.

Top module: `dpage_addr_unit`

## Requirements
- R1: After reset the page index register and the global page register both read as 0x00, and the write lock is clear.
- R2: A read (`reg_rd` high) at offset 0x11 returns the page index register in the same cycle, in any mode.
- R3: While `special_mode` is high, every write at offset 0x11 replaces the page index register with `reg_wdata`.
- R4: While `special_mode` is low, the first write at offset 0x11 since reset is accepted and sets the lock. Later writes at 0x11 with `special_mode` low leave the register unchanged.
- R5: The lock is sticky. Raising `special_mode` does not clear it, and returning to normal mode keeps writes blocked. A write accepted in special mode does not set the lock.
- R6: The global page register sits at offset 0x10 and can be written in any mode. It keeps `reg_wdata[6:0]`, and reading it returns bit 7 as 0.
- R7: When `acc_req` is high and `acc_global` is low, `acc_addr` equals {7'b0, page index, `acc_offset`}. `acc_valid` follows `acc_req`.
- R8: When `acc_req` and `acc_global` are both high, `acc_addr` equals {global page, page index, `acc_offset`}. With the page index at 0x80, the global page at 0x14 and offset 0x00, the result is 0x148000.
- R9: A read at any offset other than 0x10 or 0x11 returns 0. A write at such an offset changes neither register and does not set the lock. A read with `reg_rd` low returns 0.
- R10: A register write changes `acc_addr` only from the cycle after the write edge. An access in the write cycle uses the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | High selects the unrestricted write mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| acc_req | input | 1 | A direct-mode access is being formed this cycle |
| acc_global | input | 1 | The access is a global instruction |
| acc_offset | input | 8 | Operand offset of the direct instruction |
| acc_valid | output | 1 | Qualifies `acc_addr` |
| acc_addr | output | 23 | Formed address |

## Verification
A page-index write and a direct access can land in the same clock cycle, and so can a lock-setting write and a mode change. The bench puts a write at offset 0x11 and an access with a known offset in one cycle. It samples `acc_addr` before the edge and expects the old page index, then samples after the edge and expects the new one. The lock is exercised by switching `special_mode` around accepted and rejected writes. Each outcome is judged by reading back through the bus and by the address the next access forms.

// File: rtl/dpage_addr_unit.sv
module dpage_addr_unit #(
  parameter int REG_AW = 8,
  parameter int DATA_W = 8,
  parameter int DP_W   = 8,
  parameter int GP_W   = 7,
  parameter int OFS_W  = 8,
  parameter logic [REG_AW-1:0] DP_OFS = 8'h11,
  parameter logic [REG_AW-1:0] GP_OFS = 8'h10,
  localparam int GA_W = GP_W + DP_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_req,
  input  logic              acc_global,
  input  logic [OFS_W-1:0]  acc_offset,
  output logic              acc_valid,
  output logic [GA_W-1:0]   acc_addr
);

  logic [DP_W-1:0] dp_q;
  logic [GP_W-1:0] gp_q;
  logic            lock_q;

  wire sel_dp = (reg_addr == DP_OFS);
  wire sel_gp = (reg_addr == GP_OFS);
  wire dp_try = reg_wr && sel_dp;
  wire dp_we  = dp_try && (special_mode || !lock_q);
  wire gp_we  = reg_wr && sel_gp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q   <= '0;
      gp_q   <= '0;
      lock_q <= 1'b0;
    end else begin
      if (dp_we) dp_q <= reg_wdata[DP_W-1:0];
      if (gp_we) gp_q <= reg_wdata[GP_W-1:0];
      if (dp_try && !special_mode) lock_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_dp)      reg_rdata = DATA_W'(dp_q);
      else if (sel_gp) reg_rdata = DATA_W'(gp_q);
    end
  end

  wire [GP_W-1:0] upper = acc_global ? gp_q : {GP_W{1'b0}};

  assign acc_valid = acc_req;
  assign acc_addr  = {upper, dp_q, acc_offset};

endmodule

module dpage_addr_unit_chk #(
  parameter int REG_AW = 8,
  parameter int DATA_W = 8,
  parameter int DP_W   = 8,
  parameter int GP_W   = 7,
  parameter int OFS_W  = 8,
  parameter logic [REG_AW-1:0] DP_OFS = 8'h11,
  parameter logic [REG_AW-1:0] GP_OFS = 8'h10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          special_mode,
  input logic                          reg_wr,
  input logic                          reg_rd,
  input logic [REG_AW-1:0]             reg_addr,
  input logic [DATA_W-1:0]             reg_wdata,
  input logic [DATA_W-1:0]             reg_rdata,
  input logic                          acc_req,
  input logic                          acc_global,
  input logic [GP_W+DP_W+OFS_W-1:0]    acc_addr,
  input logic [DP_W-1:0]               dp_q,
  input logic                          lock_q
);

  a_r3_special_write: assert property (@(posedge clk) disable iff (!rst_n)
    (special_mode && reg_wr && reg_addr == DP_OFS) |=> dp_q == $past(reg_wdata[DP_W-1:0]));

  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !special_mode && reg_wr && reg_addr == DP_OFS) |=> $stable(dp_q));

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  a_r6_gp_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == GP_OFS) |-> reg_rdata[DATA_W-1:GP_W] == '0);

  a_r7_local_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_global) |-> acc_addr[GP_W+DP_W+OFS_W-1:DP_W+OFS_W] == '0);

  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr != DP_OFS && reg_addr != GP_OFS) |-> reg_rdata == '0);

  a_r10_page_field: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> acc_addr[DP_W+OFS_W-1:OFS_W] == dp_q);

endmodule

bind dpage_addr_unit dpage_addr_unit_chk #(
  .REG_AW(REG_AW), .DATA_W(DATA_W), .DP_W(DP_W), .GP_W(GP_W), .OFS_W(OFS_W),
  .DP_OFS(DP_OFS), .GP_OFS(GP_OFS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .reg_wr(reg_wr),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .acc_req(acc_req), .acc_global(acc_global),
  .acc_addr(acc_addr), .dp_q(dp_q), .lock_q(lock_q)
);

// File: tb/dpage_addr_unit_tb.sv
module dpage_addr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        special_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        acc_req = 1'b0;
  logic        acc_global = 1'b0;
  logic [7:0]  acc_offset = '0;
  logic        acc_valid;
  logic [22:0] acc_addr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dpage_addr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_req(acc_req), .acc_global(acc_global), .acc_offset(acc_offset),
    .acc_valid(acc_valid), .acc_addr(acc_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; acc_req = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #2;
    check(req, int'(reg_rdata), exp);
    reg_rd = 1'b0;
  endtask

  task automatic acc_chk(input string req, input logic g, input logic [7:0] off, input int exp);
    @(negedge clk);
    acc_req = 1'b1; acc_global = g; acc_offset = off;
    #2;
    check(req, int'(acc_addr), exp);
    check(req, int'(acc_valid), 1);
    acc_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    rd_chk("R1", 8'h11, 0);
    rd_chk("R1", 8'h10, 0);
    acc_chk("R1", 1'b1, 8'h5A, 32'h5A);

    special_mode = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(8'h11, 8'(v));
      rd_chk("R3", 8'h11, v);
    end
    for (int v = 0; v < 256; v += 3) begin
      wr(8'h10, 8'(v));
      rd_chk("R6", 8'h10, v & 8'h7F);
    end
    rd_chk("R2", 8'h11, 255);

    for (int dp = 0; dp < 256; dp += 51) begin
      for (int gp = 0; gp < 128; gp += 37) begin
        wr(8'h11, 8'(dp));
        wr(8'h10, 8'(gp));
        for (int off = 0; off < 256; off += 15) begin
          acc_chk("R7", 1'b0, 8'(off), dp * 256 + off);
          acc_chk("R8", 1'b1, 8'(off), gp * 65536 + dp * 256 + off);
        end
      end
    end
    wr(8'h11, 8'h80);
    wr(8'h10, 8'h14);
    acc_chk("R8", 1'b1, 8'h00, 32'h148000);

    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h11; reg_wdata = 8'h3C;
    acc_req = 1'b1; acc_global = 1'b1; acc_offset = 8'h07;
    #2;
    check("R10", int'(acc_addr), 32'h148007);
    @(posedge clk);
    #2;
    check("R10", int'(acc_addr), 32'h143C07);
    @(negedge clk);
    reg_wr = 1'b0; acc_req = 1'b0;

    do_reset();
    special_mode = 1'b0;
    wr(8'h11, 8'h33);
    rd_chk("R4", 8'h11, 8'h33);
    wr(8'h11, 8'h44);
    rd_chk("R4", 8'h11, 8'h33);
    acc_chk("R4", 1'b0, 8'h01, 32'h3301);
    wr(8'h10, 8'h22);
    rd_chk("R6", 8'h10, 8'h22);
    special_mode = 1'b1;
    wr(8'h11, 8'h55);
    rd_chk("R5", 8'h11, 8'h55);
    special_mode = 1'b0;
    wr(8'h11, 8'h66);
    rd_chk("R5", 8'h11, 8'h55);

    do_reset();
    special_mode = 1'b1;
    wr(8'h11, 8'h12);
    special_mode = 1'b0;
    wr(8'h11, 8'h34);
    rd_chk("R5", 8'h11, 8'h34);
    wr(8'h11, 8'h56);
    rd_chk("R5", 8'h11, 8'h34);

    do_reset();
    rd_chk("R1", 8'h11, 0);
    wr(8'h11, 8'h77);
    rd_chk("R1", 8'h11, 8'h77);

    do_reset();
    for (int a = 0; a < 256; a += 7) begin
      if (a != 8'h10 && a != 8'h11) begin
        wr(8'(a), 8'hA5);
        rd_chk("R9", 8'(a), 0);
      end
    end
    rd_chk("R9", 8'h11, 0);
    rd_chk("R9", 8'h10, 0);
    wr(8'h11, 8'h21);
    rd_chk("R9", 8'h11, 8'h21);
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 8'h11;
    #2;
    check("R9", int'(reg_rdata), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule